// File: doc/BRIEF.md
# Early Release Sync Word Injector

This block runs the closing phase of a configuration load. The main configuration data has already gone into the target's data port. A start request makes the block wait until the configuration FIFO reports empty. It then saves the clock-to-data ratio currently programmed and writes the x1 ratio code in its place. After that it sends all-ones filler words through a valid/ready data port until the target reports early user mode. Successive words are spaced by a fixed gap in clock cycles. An overall budget in clock cycles limits how long the block keeps trying.

On either outcome the block writes the saved ratio back and raises `done`. It raises `timed_out` as well if the budget ran out. `extra_words` gives the number of filler words that were accepted. The results hold until the next start.

The state machine (`sw_pkg::inj_state_t`) has these states:
- IDLE: waits for `start`.
- DRAIN: waits for the FIFO to report empty.
- FORCE: writes the x1 code.
- PROBE: tests early user mode and the budget.
- SEND: offers one word.
- GAP: the inter-word wait.
- RESTORE: writes back the saved ratio.
- FIN: results are held.

Transitions:
- IDLE→DRAIN and FIN→DRAIN on `start`, which also captures `ratio_in`.
- DRAIN→FORCE on `cfg_fifo_empty`.
- FORCE→PROBE unconditionally.
- PROBE→RESTORE on early user mode, or when the budget is spent. The timeout flag is set in the budget case.
- PROBE→SEND otherwise.
- SEND→GAP on a handshake.
- GAP→PROBE when the gap count is reached.
- RESTORE→FIN unconditionally.

Top module: `sw_sync_injector`

## Requirements
- R1: After reset the block is idle: `tx_valid`, `ratio_we`, `ratio_ovr`, `done` and `timed_out` are all 0.
- R2: After `start`, no ratio write and no data word occur while `cfg_fifo_empty` is 0.
- R3: The first ratio write of a run carries the x1 code 0 (`ratio_wdata` = 0 with `ratio_we` = 1). `ratio_ovr` is 1 whenever a word is offered.
- R4: Every offered word is 0xFFFFFFFF. While `tx_ready` is 0, `tx_valid` stays 1 and `tx_data` stays stable.
- R5: With `tx_ready` held at 1, successive accepted words are exactly GAP_CYC+2 cycles apart.
- R6: Once `early_user` is seen, no further word is sent. `extra_words` equals the number of accepted words, and `timed_out` is 0.
- R7: If `early_user` is already 1 when the FIFO drains, the run finishes with `extra_words` = 0 and no word offered.
- R8: If `early_user` never appears, the run ends with `timed_out` = 1. With `tx_ready` at 1, `extra_words` = ceil(BUDGET_CYC/(GAP_CYC+2)).
- R9: The last ratio write of every run, on success and on timeout alike, carries the `ratio_in` value captured at `start`. `ratio_ovr` is 0 while `done` is 1.
- R10: `done`, `timed_out` and `extra_words` hold their values until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run (accepted in IDLE or FIN) |
| cfg_fifo_empty | input | 1 | Configuration FIFO reports empty |
| early_user | input | 1 | Target reports early user mode |
| ratio_in | input | RW | Currently programmed clock-to-data ratio code |
| tx_data | output | DW | Filler word |
| tx_valid | output | 1 | Filler word offered |
| tx_ready | input | 1 | Data port accepts the word |
| ratio_we | output | 1 | One-cycle ratio write strobe |
| ratio_wdata | output | RW | Ratio code written |
| ratio_ovr | output | 1 | Ratio override in force |
| done | output | 1 | Run finished |
| timed_out | output | 1 | Run finished because the budget ran out |
| extra_words | output | CW | Count of accepted filler words |

## Verification
On every cycle the assertions check the data port's hold rule and that a word is only offered under the override. They also check that the count moves by exactly one per handshake, that a timeout is only reported alongside `done`, and that `done` rises only after a ratio write. The scenarios cover what depends on a whole run:
- the write order, x1 first and the saved code last;
- the spacing between words;
- the stop once early user mode appears;
- the zero-word run;
- the exact number of words before the budget runs out.

// File: rtl/sw_pkg.sv
package sw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_FORCE,
        ST_PROBE,
        ST_SEND,
        ST_GAP,
        ST_RESTORE,
        ST_FIN
    } inj_state_t;
endpackage

// File: rtl/sw_tick_cnt.sv
module sw_tick_cnt #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic hit
);
    localparam int TW = $clog2(LIMIT + 2);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (en && cnt < TW'(LIMIT))
            cnt <= cnt + 1'b1;
    end

    assign hit = (cnt >= TW'(LIMIT));

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= TW'(LIMIT)); // R8
endmodule

// File: rtl/sw_sync_injector.sv
module sw_sync_injector #(
    parameter int DW         = 32,
    parameter int RW         = 3,
    parameter int CW         = 16,
    parameter int GAP_CYC    = 4,
    parameter int BUDGET_CYC = 64,
    parameter logic [RW-1:0] X1_CODE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cfg_fifo_empty,
    input  logic          early_user,
    input  logic [RW-1:0] ratio_in,
    output logic [DW-1:0] tx_data,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic          ratio_we,
    output logic [RW-1:0] ratio_wdata,
    output logic          ratio_ovr,
    output logic          done,
    output logic          timed_out,
    output logic [CW-1:0] extra_words
);
    import sw_pkg::*;

    localparam int GAP_LIM = (GAP_CYC > 1) ? GAP_CYC - 1 : 0;
    localparam logic [DW-1:0] FILL = {DW{1'b1}};

    inj_state_t    state, nxt;
    logic [RW-1:0] saved_q;
    logic          tmo_q;
    logic [CW-1:0] words_q;
    logic          gap_hit, budget_hit;
    logic          accept, go;

    assign accept = tx_valid && tx_ready;
    assign go     = start && (state == ST_IDLE || state == ST_FIN);

    sw_tick_cnt #(.LIMIT(GAP_LIM)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == ST_SEND),
        .en    (state == ST_GAP),
        .hit   (gap_hit)
    );

    sw_tick_cnt #(.LIMIT(BUDGET_CYC)) u_budget (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == ST_FORCE),
        .en    (state == ST_PROBE || state == ST_SEND || state == ST_GAP),
        .hit   (budget_hit)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_DRAIN;
            ST_DRAIN:   if (cfg_fifo_empty) nxt = ST_FORCE;
            ST_FORCE:   nxt = ST_PROBE;
            ST_PROBE:   nxt = (early_user || budget_hit) ? ST_RESTORE : ST_SEND;
            ST_SEND:    if (tx_ready) nxt = ST_GAP;
            ST_GAP:     if (gap_hit) nxt = ST_PROBE;
            ST_RESTORE: nxt = ST_FIN;
            ST_FIN:     if (start) nxt = ST_DRAIN;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            saved_q <= '0;
            tmo_q   <= 1'b0;
            words_q <= '0;
        end else begin
            state <= nxt;
            if (go) begin
                saved_q <= ratio_in;
                tmo_q   <= 1'b0;
                words_q <= '0;
            end else begin
                if (state == ST_PROBE && !early_user && budget_hit)
                    tmo_q <= 1'b1;
                if (accept)
                    words_q <= words_q + 1'b1;
            end
        end
    end

    always_comb begin
        tx_valid    = 1'b0;
        tx_data     = '0;
        ratio_we    = 1'b0;
        ratio_wdata = saved_q;
        ratio_ovr   = 1'b0;
        done        = 1'b0;
        unique case (state)
            ST_FORCE: begin
                ratio_we    = 1'b1;
                ratio_wdata = X1_CODE;
                ratio_ovr   = 1'b1;
            end
            ST_PROBE, ST_GAP: ratio_ovr = 1'b1;
            ST_SEND: begin
                ratio_ovr = 1'b1;
                tx_valid  = 1'b1;
                tx_data   = FILL;
            end
            ST_RESTORE: ratio_we = 1'b1;
            ST_FIN:     done     = 1'b1;
            default: ;
        endcase
    end

    assign timed_out   = tmo_q && done;
    assign extra_words = words_q;

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R4
    AST_TX_UNDER_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ratio_ovr); // R3
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> extra_words == $past(extra_words) + 1'b1); // R6
    AST_TMO_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        timed_out |-> done && !ratio_ovr); // R9
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(ratio_we)); // R9
    AST_DRAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_DRAIN |-> !ratio_we && !tx_valid); // R2
endmodule

// File: tb/sim_sw_sync_injector.sv
module sim_sw_sync_injector;
    localparam int DW = 32, RW = 3, CW = 16, GAP = 4, BUDGET = 64;

    logic          clk = 0, rst_n = 0;
    logic          start = 0, cfg_fifo_empty = 0, early_user = 0, tx_ready = 1;
    logic [RW-1:0] ratio_in = '0;
    logic [DW-1:0] tx_data;
    logic          tx_valid, ratio_we, ratio_ovr, done, timed_out;
    logic [RW-1:0] ratio_wdata;
    logic [CW-1:0] extra_words;

    int vectors = 0, errors = 0, cyc = 0;
    int hs_total = 0, we_total = 0, bad_fill = 0, valid_seen = 0;
    logic [RW-1:0] we_log [64];
    int            hs_cyc [64];

    always #2 clk = ~clk;

    sw_sync_injector #(.DW(DW), .RW(RW), .CW(CW), .GAP_CYC(GAP), .BUDGET_CYC(BUDGET)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_fifo_empty(cfg_fifo_empty),
        .early_user(early_user), .ratio_in(ratio_in), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .ratio_we(ratio_we),
        .ratio_wdata(ratio_wdata), .ratio_ovr(ratio_ovr), .done(done),
        .timed_out(timed_out), .extra_words(extra_words)
    );

    always @(negedge clk) begin
        cyc++;
        if (tx_valid) begin
            valid_seen++;
            if (tx_data !== 32'hFFFF_FFFF) bad_fill++;
        end
        if (tx_valid && tx_ready) begin
            hs_cyc[hs_total % 64] = cyc;
            hs_total++;
        end
        if (ratio_we) begin
            we_log[we_total % 64] = ratio_wdata;
            we_total++;
        end
        if (cyc > 100000) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected < 100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic kick(input logic [RW-1:0] r);
        ratio_in = r;
        start = 1;
        tick();
        start = 0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000 && !done; i++) tick();
    endtask

    task automatic t_reset();
        #3;
        chk("R1 valid", tx_valid, 0);
        chk("R1 we", ratio_we, 0);
        chk("R1 ovr", ratio_ovr, 0);
        chk("R1 done", done, 0);
        chk("R1 tmo", timed_out, 0);
    endtask

    task automatic t_already_early();
        int w0, v0;
        w0 = we_total; v0 = valid_seen;
        early_user = 1; cfg_fifo_empty = 1;
        kick(3'd5);
        wait_done();
        #1;
        chk("R7 done", done, 1);
        chk("R7 count", extra_words, 0);
        chk("R7 no word offered", valid_seen - v0, 0);
        chk("R3 first write x1", we_log[w0 % 64], 0);
        chk("R9 restore saved", we_log[(we_total - 1) % 64], 5);
        chk("R9 two writes", we_total - w0, 2);
        chk("R9 ovr off at done", ratio_ovr, 0);
        early_user = 0;
    endtask

    task automatic t_early_after3();
        int h0, w0;
        h0 = hs_total; w0 = we_total;
        cfg_fifo_empty = 1; tx_ready = 1;
        kick(3'd6);
        for (int i = 0; i < 500 && hs_total - h0 < 3; i++) tick();
        early_user = 1;
        wait_done();
        #1;
        chk("R6 count", extra_words, 3);
        chk("R6 handshakes", hs_total - h0, 3);
        chk("R6 no timeout", timed_out, 0);
        chk("R5 spacing", hs_cyc[(h0 + 1) % 64] - hs_cyc[h0 % 64], GAP + 2);
        chk("R5 spacing 2", hs_cyc[(h0 + 2) % 64] - hs_cyc[(h0 + 1) % 64], GAP + 2);
        chk("R3 first write x1", we_log[w0 % 64], 0);
        chk("R9 restore saved", we_log[(we_total - 1) % 64], 6);
        for (int i = 0; i < 5; i++) tick();
        chk("R10 done holds", done, 1);
        chk("R10 count holds", extra_words, 3);
        early_user = 0;
    endtask

    task automatic t_timeout();
        int h0, w0;
        h0 = hs_total; w0 = we_total;
        cfg_fifo_empty = 1; tx_ready = 1; early_user = 0;
        kick(3'd2);
        wait_done();
        #1;
        chk("R8 timeout flag", timed_out, 1);
        chk("R8 count", extra_words, (BUDGET + GAP + 1) / (GAP + 2));
        chk("R8 handshakes", hs_total - h0, (BUDGET + GAP + 1) / (GAP + 2));
        chk("R9 restore on timeout", we_log[(we_total - 1) % 64], 2);
        chk("R9 ovr off", ratio_ovr, 0);
        chk("R4 fill words", bad_fill, 0);
    endtask

    task automatic t_fifo_wait();
        int w0, v0;
        w0 = we_total; v0 = valid_seen;
        cfg_fifo_empty = 0; early_user = 0;
        kick(3'd1);
        chk("R10 cleared by start", done, 0);
        for (int i = 0; i < 10; i++) tick();
        chk("R2 no write before empty", we_total - w0, 0);
        chk("R2 no word before empty", valid_seen - v0, 0);
        cfg_fifo_empty = 1;
        tick(); tick();
        chk("R3 x1 after empty", we_log[w0 % 64], 0);
        chk("R3 ovr on", ratio_ovr, 1);
        early_user = 1;
        wait_done();
        #1;
        chk("R9 restore", we_log[(we_total - 1) % 64], 1);
        early_user = 0;
    endtask

    task automatic t_backpressure();
        int h0;
        h0 = hs_total;
        cfg_fifo_empty = 1; tx_ready = 0; early_user = 0;
        kick(3'd4);
        for (int i = 0; i < 20 && !tx_valid; i++) tick();
        for (int i = 0; i < 6; i++) tick();
        #0;
        chk("R4 valid held", tx_valid, 1);
        chk("R4 data all ones", tx_data, 32'hFFFF_FFFF);
        chk("R4 no handshake", hs_total - h0, 0);
        early_user = 1;
        tx_ready = 1;
        wait_done();
        #1;
        chk("R6 count one", extra_words, 1);
        chk("R4 fill words", bad_fill, 0);
        early_user = 0;
    endtask

    initial begin
        t_reset();
        tick();
        rst_n = 1;
        tick();
        t_already_early();
        t_early_after3();
        t_timeout();
        t_fifo_wait();
        t_backpressure();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule